// File: doc/BRIEF.md
# Serial Control and Status Shift Port

This block is a 16-bit synchronous serial slave. A host selects it by pulling the active-low select line low, then toggles the serial clock. On every frame the host shifts a control word in on the data input, and the block shifts its status word out on the data output. Both words travel least significant bit first. The select, clock and data pins are asynchronous to the block. A fast system clock oversamples them, passes them through a synchronizer and runs edge detection on them. For this reason the system clock must run at least eight times faster than the fastest serial clock.

The status word is taken from the `status_i` input at the moment the frame opens. Its bit 0 is visible on the data output before the first clock pulse. A host can therefore read that one bit and close the frame at once. Such a frame has no effect on anything.

The shifted control word reaches the control register only when the frame closes, and only if exactly sixteen falling serial-clock edges were seen. Serial input enters at the top of the same register that carries the status out. Once sixteen bits have gone in, the data output repeats the input delayed by sixteen clocks, so several ports can be chained in series. While the port is not selected, the data output is released, which lets several ports share one return line.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset, `ctrl_o` is 0x2000 and `do_oe_o` is low. Bit 13 (overcurrent-shutdown enable) is high; bits 0 to 6 (status reset and the three low/high switch pairs) and all other bits are low.
- R2: `do_oe_o` goes high after `cs_n_i` falls and low after it rises. The output is never driven while the port is deselected.
- R3: After `cs_n_i` falls and before any serial clock pulse, `do_o` shows bit 0 of `status_i`.
- R4: After the k-th rising edge of `sclk_i` in a frame (k = 1 to 16), `do_o` shows status bit k-1. The value holds until the next rising edge.
- R5: `di_i` is sampled on each falling edge of `sclk_i`. The first sampled bit becomes bit 0 of the word. When a frame with exactly 16 falling edges closes, `ctrl_o` takes that word.
- R6: `ctrl_o` does not change while a frame is open. It changes only when a frame closes.
- R7: A frame with fewer than 16 falling edges, including one with none, leaves `ctrl_o` unchanged when it closes.
- R8: A frame with more than 16 falling edges leaves `ctrl_o` unchanged when it closes.
- R9: From the 17th rising edge of a frame onward, `do_o` shows the `di_i` bit sampled 16 falling edges earlier, so ports can be chained in series.
- R10: The status word is captured when the frame opens. Changes on `status_i` during the frame do not alter the bits shifted out.
- R11: `ctrl_upd_o` pulses high for exactly one system cycle for each committed frame. It stays low for frames that are discarded.
- R12: Serial clock activity while `cs_n_i` is high has no effect on `ctrl_o` or `do_oe_o`. It also does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, LSB first |
| status_i | input | WORD_W | Status word, captured at frame open |
| do_o | output | 1 | Serial data out, LSB first |
| do_oe_o | output | 1 | Output enable for the shared data-out line |
| ctrl_o | output | WORD_W | Committed control word |
| ctrl_upd_o | output | 1 | One-cycle strobe when a control word is committed |

## Verification
The bench runs frames with 0, 9, 16 and 20 clock edges. A design that commits on a wrong bit count would corrupt the control register on a short read of the warning bit, or on a word that overran in a chain. It changes `status_i` in the middle of a frame; a design that shifts live status instead of a snapshot would send out a mixed word. It checks the bits that follow the sixteenth rising edge, which catches a design that shifts in at the wrong end or from the wrong edge. It also toggles the serial clock while the port is deselected, which catches a design whose bit counter or output enable does not look at the select line.

// File: rtl/scp_pkg.sv
package scp_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } pin_evt_t;

  // Edge events from the previous and current synchronized level.
  function automatic pin_evt_t edge_of(input logic prev, input logic now);
    pin_evt_t e;
    e.rise = ~prev & now;
    e.fall = prev & ~now;
    return e;
  endfunction

  // Counter width able to hold word_w + 1 (saturation marker for overrun).
  function automatic int unsigned count_bits(input int unsigned word_w);
    return $clog2(word_w + 2);
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/scp_edge.sv
module scp_edge #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  output scp_pkg::pin_evt_t evt_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LVL;
    else        prev_q <= lvl_i;
  end

  assign evt_o = scp_pkg::edge_of(prev_q, lvl_i);

endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scp_pkg::pin_evt_t cs_evt_i,   // rise = frame closes, fall = frame opens
  input  scp_pkg::pin_evt_t sclk_evt_i,
  input  logic              di_i,
  input  logic [WORD_W-1:0] status_i,
  output logic [WORD_W-1:0] word_o,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              frame_ok_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(WORD_W + 1);

  // Saturating bit counter: stops at WORD_W+1 so that an overrun is kept.
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == OVER_CNT) ? c : c + 1'b1;
  endfunction

  // New bit enters at the top, the register moves toward bit 0.
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] w,
                                                 input logic b);
    return {b, w[WORD_W-1:1]};
  endfunction

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q;
  logic              do_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      do_q  <= 1'b0;
    end else if (cs_evt_i.fall) begin
      sh_q  <= status_i;
      cnt_q <= '0;
      act_q <= 1'b1;
      do_q  <= status_i[0];
    end else if (cs_evt_i.rise) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (sclk_evt_i.fall) begin
        sh_q  <= shift_in(sh_q, di_i);
        cnt_q <= bump(cnt_q);
      end else if (sclk_evt_i.rise) begin
        do_q  <= sh_q[0];
      end
    end
  end

  assign word_o     = sh_q;
  assign do_o       = do_q;
  assign do_oe_o    = act_q;
  assign frame_ok_o = act_q & cs_evt_i.rise & (cnt_q == FULL_CNT);

endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] RST_WORD    = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              di_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              ctrl_upd_o
);

  localparam int unsigned CNT_W    = scp_pkg::count_bits(WORD_W);
  localparam logic [2:0]  PIN_IDLE = 3'b100;   // {cs_n, sclk, di}

  logic [2:0]        pins_s;
  scp_pkg::pin_evt_t cs_evt, sclk_evt;
  logic [WORD_W-1:0] shift_word;

  // Named internal events for the checker.
  logic cs_fall_w, cs_rise_w, sclk_fall_w, sclk_rise_w, frame_ok_w;

  scp_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({cs_n_i, sclk_i, di_i}),
    .q_o(pins_s)
  );

  scp_edge #(.RST_LVL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pins_s[2]), .evt_o(cs_evt)
  );

  scp_edge #(.RST_LVL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pins_s[1]), .evt_o(sclk_evt)
  );

  assign cs_fall_w   = cs_evt.fall;
  assign cs_rise_w   = cs_evt.rise;
  assign sclk_fall_w = sclk_evt.fall;
  assign sclk_rise_w = sclk_evt.rise;

  scp_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cs_evt_i(cs_evt),
    .sclk_evt_i('{rise: sclk_rise_w, fall: sclk_fall_w}),
    .di_i(pins_s[0]),
    .status_i(status_i),
    .word_o(shift_word),
    .do_o(do_o),
    .do_oe_o(do_oe_o),
    .frame_ok_o(frame_ok_w)
  );

  // Commit on a complete frame only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o     <= RST_WORD[WORD_W-1:0];
      ctrl_upd_o <= 1'b0;
    end else begin
      ctrl_upd_o <= frame_ok_w;
      if (frame_ok_w) ctrl_o <= shift_word;
    end
  end

endmodule

// File: rtl/ser_ctl_port_chk.sv
module ser_ctl_port_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] status_i,
  input logic [WORD_W-1:0] ctrl_o,
  input logic              ctrl_upd_o,
  input logic              do_o,
  input logic              do_oe_o,
  input logic              cs_fall_w,
  input logic              cs_rise_w,
  input logic              frame_ok_w
);

  // R2
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_w |=> do_oe_o);

  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_w |=> !do_oe_o);

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_w |=> (do_o == $past(status_i[0])));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> ctrl_upd_o);

  // R7
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_upd_o |-> $past(frame_ok_w));

  // R11
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_upd_o |=> !ctrl_upd_o);

endmodule

bind ser_ctl_port ser_ctl_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .status_i(status_i),
  .ctrl_o(ctrl_o),
  .ctrl_upd_o(ctrl_upd_o),
  .do_o(do_o),
  .do_oe_o(do_oe_o),
  .cs_fall_w(cs_fall_w),
  .cs_rise_w(cs_rise_w),
  .frame_ok_w(frame_ok_w)
);

// File: tb/ser_ctl_port_tb.sv
module ser_ctl_port_tb;

  localparam int HALF = 8;   // system cycles per serial half period
  localparam int K_DO = 0, K_OE = 1, K_CTRL = 2, K_UPD = 3;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, di;
  logic [15:0] status;
  logic        do_w, do_oe_w, upd_w;
  logic [15:0] ctrl_w;

  int    n_chk = 0, n_bad = 0, upd_seen = 0, exp_upd = 0;
  bit    done = 1'b0;
  item_t q[$];
  event  chk_ev;

  always #4 clk = ~clk;

  ser_ctl_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .di_i(di),
    .status_i(status), .do_o(do_w), .do_oe_o(do_oe_w),
    .ctrl_o(ctrl_w), .ctrl_upd_o(upd_w)
  );

  always @(posedge clk) if (rst_n && upd_w) upd_seen++;

  // Monitor: pops expected items and compares against the ports.
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        K_DO:    act = {15'b0, do_w};
        K_OE:    act = {15'b0, do_oe_w};
        K_CTRL:  act = ctrl_w;
        default: act = upd_seen[15:0];
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic push_exp(input int k, input logic [15:0] e, input string r);
    q.push_back('{k, e, r});
    -> chk_ev;
    #1;
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame(input logic [15:0] st);
    status = st;
    cs_n   = 1'b0;
    wait_sys(HALF);
  endtask

  task automatic close_frame();
    cs_n = 1'b1;
    wait_sys(HALF);
  endtask

  // Drives n serial bits; status bits expected first, then the delayed DI.
  task automatic clock_bits(input logic [31:0] data, input int n,
                            input logic [15:0] st, input string st_req);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      di   = data[i];
      wait_sys(HALF);
      if (i < 16) push_exp(K_DO, {15'b0, st[i]}, st_req);
      else        push_exp(K_DO, {15'b0, data[i-16]}, "R9");
      sclk = 1'b0;
      wait_sys(HALF);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; di = 1'b0; status = '0;
    wait_sys(5);
    rst_n = 1'b1;
    wait_sys(4);
    push_exp(K_CTRL, 16'h2000, "R1");
    push_exp(K_OE, 16'h0, "R1");

    // Full frame
    open_frame(16'hA5C3);
    push_exp(K_OE, 16'h1, "R2");
    push_exp(K_DO, 16'h1, "R3");
    clock_bits(32'h0000_0055, 16, 16'hA5C3, "R4");
    push_exp(K_CTRL, 16'h2000, "R6");
    close_frame();
    push_exp(K_CTRL, 16'h0055, "R5");
    push_exp(K_OE, 16'h0, "R2");
    exp_upd++;
    push_exp(K_UPD, exp_upd[15:0], "R11");

    // Status changes mid-frame must not leak out
    open_frame(16'h3C96);
    push_exp(K_DO, 16'h0, "R3");
    status = 16'hFFFF;
    clock_bits(32'h0000_204A, 16, 16'h3C96, "R10");
    close_frame();
    push_exp(K_CTRL, 16'h204A, "R5");
    exp_upd++;
    push_exp(K_UPD, exp_upd[15:0], "R11");

    // Quick read of bit 0, then abort
    open_frame(16'h0001);
    push_exp(K_DO, 16'h1, "R3");
    close_frame();
    push_exp(K_CTRL, 16'h204A, "R7");
    push_exp(K_UPD, exp_upd[15:0], "R11");

    // Short frame
    open_frame(16'h0000);
    clock_bits(32'h0000_1234, 9, 16'h0000, "R4");
    close_frame();
    push_exp(K_CTRL, 16'h204A, "R7");
    push_exp(K_UPD, exp_upd[15:0], "R11");

    // Overrun frame, also the chain pass-through
    open_frame(16'h8001);
    clock_bits(32'h000A_BCDE, 20, 16'h8001, "R4");
    close_frame();
    push_exp(K_CTRL, 16'h204A, "R8");
    push_exp(K_UPD, exp_upd[15:0], "R8");

    // Serial clock while deselected
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; di = 1'b1; wait_sys(HALF);
      sclk = 1'b0; wait_sys(HALF);
    end
    push_exp(K_OE, 16'h0, "R12");
    push_exp(K_CTRL, 16'h204A, "R12");
    open_frame(16'h0F0F);
    clock_bits(32'h0000_1111, 16, 16'h0F0F, "R12");
    close_frame();
    push_exp(K_CTRL, 16'h1111, "R12");
    exp_upd++;
    push_exp(K_UPD, exp_upd[15:0], "R11");

    // Reset returns the default word
    rst_n = 1'b0;
    wait_sys(2);
    rst_n = 1'b1;
    wait_sys(4);
    push_exp(K_CTRL, 16'h2000, "R1");
    push_exp(K_OE, 16'h0, "R1");

    done = 1'b1;
    summary();
  end

endmodule